// File: doc/BRIEF.md
# Residue-Form Sign Detector

This block decides the sign of an integer held in residue form over three pairwise-coprime moduli: m1 = 2^(N+1)-1, m2 = 2^N-1 and m3 = 2^N, with N = 16 by default. The dynamic range is M = m1·m2·m3. Values in the lower half of [0, M) count as non-negative and values in the upper half count as negative. The block returns that one bit without converting the number back to binary.

The sign equals the top bit of the highest mixed-radix digit, and that digit is taken modulo 2^N. Because m1 and m2 are both congruent to -1 modulo 2^N, the digit reduces to x3 + x2 - x1 - fold(x1) - borrow, all modulo 2^N. Here fold(x1) is x1 reduced end-around modulo m2, and borrow is set when x2 < fold(x1). Two carry-save layers compress the operands into a sum vector and a carry vector. The comparator flags fill the free carry slots. A blocked generate/propagate network then finds only the carry into bit N-1. Three register stages split the work, and the block accepts one residue triple per clock.

Top module: `rns_sign_detect`

## Requirements
- R1: The result for a triple presented with `in_valid_i` high appears with `out_valid_o` high after the third rising edge, counting the edge that samples the inputs. A new triple is accepted on every cycle, and `out_valid_o` follows `in_valid_i` delayed by three cycles, including any gaps.
- R2: While `rst_ni` is low, `out_valid_o` is 0. Triples in flight when reset is applied never produce an output.
- R3: `neg_o` is 1 exactly when X ≥ M/2. X is the unique integer in [0, M) with X mod (2^(N+1)-1) = `x1_i`, X mod (2^N-1) = `x2_i` and X mod 2^N = `x3_i`.
- R4: X = M/2, encoded as (0, 0, 2^(N-1)), is reported negative. X = M/2-1 is reported non-negative.
- R5: X = 0 is reported non-negative, and X = M-1 is reported negative.
- R6: The result is correct when `x1_i` folds to all ones modulo 2^N-1, that is for `x1_i` = 2^N-1 and `x1_i` = 2^(N+1)-2, in both halves of the range.
- R7: The result is correct when `x2_i` is equal to, greater than or less than the folded `x1_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input triple is valid this cycle |
| x1_i | input | N+1 | Residue modulo 2^(N+1)-1 |
| x2_i | input | N | Residue modulo 2^N-1 |
| x3_i | input | N | Residue modulo 2^N |
| out_valid_o | output | 1 | `neg_o` is valid |
| neg_o | output | 1 | 1 when the encoded value lies in the upper half of the range |

## Verification
The bench aims at the exact half-range boundary, where an off-by-one in the borrow or the constant carry-in would flip the answer for M/2 or for M/2-1. It drives x1 values that fold to all ones, where a design that forced a full reduction or dropped the end-around bit would misreport. It also drives triples that put x2 equal to the folded x1, where a comparator that treated equality as a borrow would invert the sign. Gapped streams and a reset taken with data in flight expose a valid pipeline that is misaligned with the data or that leaks stale results.

// File: rtl/rns_sign_pkg.sv
package rns_sign_pkg;
  parameter int unsigned N_DEF   = 16;
  parameter int unsigned BLK_DEF = 4;
endpackage

// File: rtl/rns_csa.sv
// Carry-save compressor; carry vector comes out pre-shifted with cin_i in bit 0.
module rns_csa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  assign cy_o[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    if (i < W - 1) begin : g_cy
      assign cy_o[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
    end
  end
endmodule

// File: rtl/rns_fold_cmp.sv
// End-around fold of x1 modulo 2^N-1, then magnitude compare against x2.
module rns_fold_cmp #(
  parameter int unsigned N = 16
) (
  input  logic [N:0]   x1_i,
  input  logic [N-1:0] x2_i,
  output logic [N-1:0] x1f_o,
  output logic         gt_o,
  output logic         eq_o
);
  // all-ones result is left unreduced: it behaves as zero downstream
  assign x1f_o = x1_i[N-1:0] + {{(N-1){1'b0}}, x1_i[N]};
  assign gt_o  = x2_i > x1f_o;
  assign eq_o  = x2_i == x1f_o;
endmodule

// File: rtl/rns_blk_gp.sv
// Per-block group generate/propagate over a W-bit addend pair.
module rns_blk_gp #(
  parameter int unsigned W   = 15,
  parameter int unsigned BLK = 4,
  localparam int unsigned NB = (W + BLK - 1) / BLK
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [NB-1:0] g_o,
  output logic [NB-1:0] p_o
);
  localparam int unsigned PADW = NB * BLK;

  logic [PADW-1:0] g_pad, p_pad;

  always_comb begin
    g_pad         = '0;
    p_pad         = '1;
    g_pad[W-1:0]  = a_i & b_i;
    p_pad[W-1:0]  = a_i ^ b_i;
  end

  for (genvar k = 0; k < NB; k++) begin : g_blk
    logic gg, pp;
    always_comb begin
      gg = 1'b0;
      pp = 1'b1;
      for (int j = 0; j < BLK; j++) begin
        gg = g_pad[k*BLK+j] | (p_pad[k*BLK+j] & gg);
        pp = pp & p_pad[k*BLK+j];
      end
    end
    assign g_o[k] = gg;
    assign p_o[k] = pp;
  end
endmodule

// File: rtl/rns_sign_detect.sv
module rns_sign_detect
  import rns_sign_pkg::*;
#(
  parameter int unsigned N   = N_DEF,
  parameter int unsigned BLK = BLK_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [N:0]   x1_i,
  input  logic [N-1:0] x2_i,
  input  logic [N-1:0] x3_i,
  output logic         out_valid_o,
  output logic         neg_o
);
  localparam int unsigned LOW = N - 1;
  localparam int unsigned NB  = (LOW + BLK - 1) / BLK;

  // ---------------- stage 1: CSA(x2, x3, ~x1) || fold + compare
  logic [N-1:0] s1_sum, s1_cy, x1f;
  logic         gt, eq;

  rns_csa #(.W(N)) u_csa1 (
    .a_i   (x2_i),
    .b_i   (x3_i),
    .c_i   (~x1_i[N-1:0]),
    .cin_i (1'b1),
    .sum_o (s1_sum),
    .cy_o  (s1_cy)
  );

  rns_fold_cmp #(.N(N)) u_fold (
    .x1_i  (x1_i),
    .x2_i  (x2_i),
    .x1f_o (x1f),
    .gt_o  (gt),
    .eq_o  (eq)
  );

  logic [N-1:0] s_q, c_q, x1f_q;
  logic         ge_q, v1_q;

  always_ff @(posedge clk_i) begin
    s_q   <= s1_sum;
    c_q   <= s1_cy;
    x1f_q <= x1f;
    ge_q  <= gt | eq;
  end

  // ---------------- stage 2: CSA(S, C, ~fold) + block gen/prop
  logic [N-1:0]  u_w, v_w;
  logic [NB-1:0] g_w, p_w;

  rns_csa #(.W(N)) u_csa2 (
    .a_i   (s_q),
    .b_i   (c_q),
    .c_i   (~x1f_q),
    .cin_i (ge_q),
    .sum_o (u_w),
    .cy_o  (v_w)
  );

  rns_blk_gp #(.W(LOW), .BLK(BLK)) u_gp (
    .a_i (u_w[LOW-1:0]),
    .b_i (v_w[LOW-1:0]),
    .g_o (g_w),
    .p_o (p_w)
  );

  logic [NB-1:0] g_q, p_q;
  logic          h_q, v2_q;

  always_ff @(posedge clk_i) begin
    g_q <= g_w;
    p_q <= p_w;
    h_q <= u_w[N-1] ^ v_w[N-1];
  end

  // ---------------- stage 3: block carry ripple, top-bit sum
  logic c_top, sign_d;

  always_comb begin
    c_top = 1'b0;
    for (int k = 0; k < NB; k++) begin
      c_top = g_q[k] | (p_q[k] & c_top);
    end
    sign_d = h_q ^ c_top;
  end

  always_ff @(posedge clk_i) begin
    neg_o <= sign_d;
  end

  // ---------------- valid pipe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      v2_q        <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      v1_q        <= in_valid_i;
      v2_q        <= v1_q;
      out_valid_o <= v2_q;
    end
  end
endmodule

// File: rtl/rns_sign_detect_chk.sv
module rns_sign_detect_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic [N:0]   x1_i,
  input logic [N-1:0] x2_i,
  input logic [N-1:0] x3_i,
  input logic         out_valid_o,
  input logic         neg_o
);
  function automatic logic ref_neg(logic [N:0] a, logic [N-1:0] b, logic [N-1:0] c);
    logic [N-1:0] f, d;
    f = a[N-1:0] + {{(N-1){1'b0}}, a[N]};
    d = c + b - a[N-1:0] - f - {{(N-1){1'b0}}, (b < f)};
    return d[N-1];
  endfunction

  logic [2:0] vq, rq, zq, hq;
  logic       zero_in, half_in;

  assign zero_in = in_valid_i && (x1_i == '0) && (x2_i == '0) && (x3_i == '0);
  assign half_in = in_valid_i && (x1_i == '0) && (x2_i == '0) &&
                   (x3_i == {1'b1, {(N-1){1'b0}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vq <= '0;
      rq <= '0;
      zq <= '0;
      hq <= '0;
    end else begin
      vq <= {vq[1:0], in_valid_i};
      rq <= {rq[1:0], ref_neg(x1_i, x2_i, x3_i)};
      zq <= {zq[1:0], zero_in};
      hq <= {hq[1:0], half_in};
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vq[2]);

  // R2
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_clear_chk: assert (!out_valid_o);
    end
  end

  // R3
  sign_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (neg_o == rq[2]));

  // R3
  sign_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$isunknown(neg_o));

  // R4
  half_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hq[2] |-> neg_o);

  // R5
  zero_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zq[2] |-> !neg_o);
endmodule

bind rns_sign_detect rns_sign_detect_chk #(.N(N)) sign_chk_i (.*);

// File: tb/rns_sign_detect_tb_top.sv
module rns_sign_detect_tb_top;
  localparam int N = 16;
  localparam longint unsigned M1   = (64'd1 << (N + 1)) - 1;
  localparam longint unsigned M2   = (64'd1 << N) - 1;
  localparam longint unsigned M3   = 64'd1 << N;
  localparam longint unsigned MM   = M1 * M2 * M3;
  localparam longint unsigned HALF = MM / 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [N:0]   x1_i = '0;
  logic [N-1:0] x2_i = '0;
  logic [N-1:0] x3_i = '0;
  logic         out_valid_o;
  logic         neg_o;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  bit     done   = 1'b0;

  bit     exp_q[$];
  longint cyc_q[$];
  string  tag_q[$];

  rns_sign_detect dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .x1_i        (x1_i),
    .x2_i        (x2_i),
    .x3_i        (x3_i),
    .out_valid_o (out_valid_o),
    .neg_o       (neg_o)
  );

  always #2 clk_i = ~clk_i;  // 250 MHz

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // output monitor: latency (R1) and sign value (tag of the scenario)
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected out_valid_o", 1, 0);
      end else begin
        bit     e;
        longint d;
        string  t;
        e = exp_q.pop_front();
        d = cyc_q.pop_front();
        t = tag_q.pop_front();
        chk(cyc - d == 3, "R1", "latency", cyc - d, 3);
        chk(neg_o == e, t, "neg_o", longint'(neg_o), longint'(e));
      end
    end
  end

  task automatic send(longint unsigned x, string tag);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    x1_i = (N + 1)'(x % M1);
    x2_i = N'(x % M2);
    x3_i = N'(x % M3);
    exp_q.push_back(x >= HALF);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1", "outputs missing", exp_q.size(), 0);
  endtask

  function automatic longint unsigned rnd_x();
    longint unsigned r;
    r = {$urandom(), $urandom()};
    return r % MM;
  endfunction

  // X at or above base with X mod M1 == r1
  function automatic longint unsigned with_x1(longint unsigned base, longint unsigned r1);
    return base + ((r1 + M1 - (base % M1)) % M1);
  endfunction

  task automatic t_reset_state();
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R2", "out_valid_o in reset", longint'(out_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R2", "out_valid_o idle after reset", longint'(out_valid_o), 0);
  endtask

  task automatic t_bounds();
    send(0, "R5");
    send(HALF - 1, "R4");
    send(HALF, "R4");
    send(MM - 1, "R5");
    send(HALF + 1, "R4");
    drain();
  endtask

  task automatic t_fold();
    send(M3 - 1, "R6");                  // x1 = 2^N-1
    send(M1 - 1, "R6");                  // x1 = 2^(N+1)-2
    send(with_x1(HALF, M3 - 1), "R6");
    send(with_x1(HALF, M1 - 1), "R6");
    send(with_x1(HALF - 4 * M1, M1 - 1), "R6");
    drain();
  endtask

  task automatic t_cmp();
    send(5, "R7");                       // x2 == folded x1
    send(M2, "R7");                      // x2 < folded x1
    send(M1 + 3, "R7");                  // x2 > folded x1
    for (int d = 0; d < 6; d++) send(HALF - 3 + longint'(d), "R7");
    for (int d = 0; d < 4; d++) send(MM - 1 - longint'(d) * M2, "R7");
    drain();
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) send(rnd_x(), "R3");
    drain();
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 60; i++) begin
      send(rnd_x(), "R1");
      if ($urandom_range(2) == 0) begin
        @(negedge clk_i);
        in_valid_i = 1'b0;
      end
    end
    drain();
  endtask

  task automatic t_reset_flight();
    send(HALF, "R2");
    send(MM - 1, "R2");
    send(HALF + 7, "R2");
    @(negedge clk_i);
    in_valid_i = 1'b0;
    #1 rst_ni = 1'b0;
    exp_q.delete();
    cyc_q.delete();
    tag_q.delete();
    repeat (2) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R2", "out_valid_o during reset", longint'(out_valid_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R2", "flushed data leaked", longint'(out_valid_o), 0);
    send(HALF, "R2");
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_bounds();
    t_fold();
    t_cmp();
    t_random();
    t_gaps();
    t_reset_flight();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule